// File: doc/BRIEF.md
# Difference-Based Output Error Corrector

This block follows a narrowband low-pass filter whose arithmetic may now and then produce a large wrong value. Each incoming filter sample is compared with the last sample the block accepted. The block subtracts the two, takes the magnitude of the result and compares that magnitude with a threshold supplied on a port. If the jump is larger than the threshold, the sample is treated as corrupt. The block then marks it and puts out the last accepted value again. A smaller jump lets the sample pass through unchanged.

The reference value is always the corrected output, never the raw input. A corrupt sample therefore cannot become the baseline for the next comparison. The hardware is one subtractor, one sample register and one magnitude comparator, plus the registered output stage. Each result appears one clock after its input strobe, together with a flag that tells whether the sample was replaced.

Top module: `sample_repair_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `out_valid` is 0, `out_err` is 0 and `out_data` is 0.
- R2: The first valid sample after reset is accepted as it is, with `out_err` = 0, whatever its value.
- R3: The difference is formed one bit wider than the data, so the full span between the most negative and most positive input gives a magnitude of 2^DW-1 with no wrap. With DW=8, -128 against 127 has magnitude 255.
- R4: The comparison is strict. A magnitude equal to `thresh` (read as unsigned) passes, and a magnitude of `thresh`+1 is an error.
- R5: When an error is declared, `out_data` equals the last accepted value and `out_err` = 1. Otherwise `out_data` equals the input sample and `out_err` = 0.
- R6: The reference for the next comparison is the corrected output. After a replaced sample, the following sample is compared with the held value, not with the rejected raw value.
- R7: Every input strobe produces exactly one `out_valid` pulse, one clock later, with `out_err` aligned to it. No strobe produces no pulse.
- R8: Cycles with `in_valid` low do not change the reference. `in_data` and `thresh` are ignored in those cycles.
- R9: With `thresh` = 0, any change from the reference is an error, and an identical value passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new filter sample |
| in_data | input | DW | Filter sample, two's complement |
| thresh | input | DW | Allowed jump magnitude, unsigned |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | DW | Corrected sample, two's complement |
| out_err | output | 1 | High when the sample was replaced |

## Verification
The bench builds the block with DW=8, the smallest width used here. At that width the most negative and most positive samples (-128 and 127) and the largest threshold (255) are easy to drive. This brings the full-span magnitude of R3 and the strict boundary of R4 within a few samples. The threshold runs from 0 up to its maximum, so both ends of the comparison are exercised. Idle gaps, a mid-run reset and a long sweep of changing samples check the reference rule against a model kept in the bench.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Default sample width for the corrector.
    localparam int SR_DEF_W = 12;

    // Whether the reference register holds an accepted sample yet.
    typedef enum logic {
        REF_EMPTY = 1'b0,
        REF_HELD  = 1'b1
    } ref_state_e;

    // Verdict on one sample.
    typedef struct packed {
        logic hit;     // jump above threshold
        logic checked; // comparison was applied
    } verdict_t;

endpackage

// File: rtl/sr_diff_mag.sv
module sr_diff_mag #(
    parameter int W = 12
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    output logic [W-1:0] mag
);
    localparam int XW = W + 1;

    logic signed [XW-1:0] delta;
    logic        [XW-1:0] delta_abs;

    always_comb begin
        delta     = $signed({cur[W-1], cur}) - $signed({prev[W-1], prev});
        delta_abs = delta[XW-1] ? XW'(-delta) : XW'(delta);
        mag       = delta_abs[W-1:0];
    end

    // R3: the widened magnitude never needs its top bit
    always_comb begin
        if (!$isunknown(delta_abs)) begin
            a_r3_no_overflow: assert (delta_abs[XW-1] == 1'b0);
        end
    end

endmodule

// File: rtl/sr_ref_hold.sv
module sr_ref_hold
    import sr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] ref_q,
    output logic         primed
);
    ref_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            state_q <= REF_EMPTY;
        end else if (load) begin
            ref_q   <= din;
            state_q <= REF_HELD;
        end
    end

    assign primed = (state_q == REF_HELD);

    // R8: without a load the reference does not move
    a_r8_ref_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ref_q));

endmodule

// File: rtl/sr_out_stage.sv
module sr_out_stage
    import sr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic [W-1:0] thresh,
    input  logic [W-1:0] ref_q,
    input  logic         primed,
    input  logic [W-1:0] mag,
    output logic [W-1:0] corrected,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_err
);
    verdict_t vd;

    always_comb begin
        vd.checked = primed;
        vd.hit     = primed && (mag > thresh);
        corrected  = vd.hit ? ref_q : in_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && vd.hit;
            if (in_valid) begin
                out_data <= corrected;
            end
        end
    end

    // R7: one result per strobe, one clock later
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R2: an empty reference never flags
    a_r2_first_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !primed) |=> !out_err);
    // R5: a flagged result repeats the previous reference
    a_r5_hold_prev: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_data == $past(ref_q)));
    // R9: a flag needs an actual change
    a_r9_change_needed: assert property (@(posedge clk) disable iff (rst)
        out_err |-> ($past(in_data) != $past(ref_q)));

endmodule

// File: rtl/sample_repair_top.sv
module sample_repair_top
    import sr_pkg::*;
#(
    parameter int DW = SR_DEF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] thresh,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_err
);
    logic [DW-1:0] ref_q;
    logic          primed;
    logic [DW-1:0] mag;
    logic [DW-1:0] corrected;

    sr_diff_mag #(.W(DW)) diff_i (
        .cur  (in_data),
        .prev (ref_q),
        .mag  (mag)
    );

    sr_ref_hold #(.W(DW)) hold_i (
        .clk    (clk),
        .rst    (rst),
        .load   (in_valid),
        .din    (corrected),
        .ref_q  (ref_q),
        .primed (primed)
    );

    sr_out_stage #(.W(DW)) out_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .thresh    (thresh),
        .ref_q     (ref_q),
        .primed    (primed),
        .mag       (mag),
        .corrected (corrected),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_err   (out_err)
    );

    // R6: the reference tracks the corrected output, not the raw input
    a_r6_ref_is_output: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (ref_q == out_data));
    // R1: reset leaves the output quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_err && out_data == '0));

endmodule

// File: tb/sample_repair_top_tb_top.sv
module sample_repair_top_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic [DW-1:0] thresh;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_err;

    int total = 0;
    int bad   = 0;

    int    exp_d[$];
    bit    exp_e[$];
    string exp_t[$];

    int m_ref    = 0;
    bit m_primed = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    sample_repair_top #(.DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .thresh    (thresh),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_err   (out_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one sample at the falling edge and pushes the expected result.
    task automatic send(input int d, input int th, input string tag);
        int mag;
        bit e;
        mag = d - m_ref;
        if (mag < 0) mag = -mag;
        e = m_primed && (mag > th);
        if (!e) m_ref = d;
        m_primed = 1;
        exp_d.push_back(m_ref);
        exp_e.push_back(e);
        exp_t.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(d);
        thresh   = DW'(th);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'h5A;
        thresh   = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = DW'(i * 53);
            thresh   = DW'(i);
        end
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_d.size() == 0) begin
                check(1'b0, "R7 unexpected out_valid", 1, 0);
            end else begin
                int    d;
                bit    e;
                string t;
                d = exp_d.pop_front();
                e = exp_e.pop_front();
                t = exp_t.pop_front();
                check(int'($signed(out_data)) == d, {t, " data"}, int'($signed(out_data)), d);
                check(out_err == e, {t, " err"}, int'(out_err), int'(e));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_err == 1'b0, "R1 flags after reset",
              int'({out_valid, out_err}), 0);
        check(out_data == '0, "R1 data after reset", int'(out_data), 0);
        m_ref = 0;
        m_primed = 0;
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        thresh = '0;
        do_reset();

        send(100, 5, "R2 first sample");
        send(103, 5, "R5 small step");
        send(108, 5, "R4 equal passes");
        send(114, 5, "R4 one above");
        send(116, 5, "R6 vs held ref");
        idle(6);
        check(exp_d.size() == 0, "R7 drained before idle", exp_d.size(), 0);
        send(110, 5, "R8 ref after idle");
        send(127, 255, "R3 setup");
        send(-128, 254, "R3 full span err");
        send(-128, 255, "R3 full span pass");
        send(127, 255, "R3 full span up");
        send(127, 0, "R9 same value");
        send(126, 0, "R9 any change");
        send(127, 0, "R9 back to ref");
        // back-to-back strobes
        for (int i = 0; i < 40; i++) begin
            int v;
            v = ((i * 37) % 256) - 128;
            exp_d.push_back(0); void'(exp_d.pop_back());
            begin
                int mag;
                bit e;
                mag = v - m_ref;
                if (mag < 0) mag = -mag;
                e = m_primed && (mag > 60);
                if (!e) m_ref = v;
                m_primed = 1;
                exp_d.push_back(m_ref);
                exp_e.push_back(e);
                exp_t.push_back("R5 sweep");
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = DW'(v);
            thresh   = 8'd60;
        end
        @(negedge clk);
        in_valid = 1'b0;
        idle(3);
        check(exp_d.size() == 0, "R7 sweep drained", exp_d.size(), 0);

        do_reset();
        send(-100, 0, "R2 first after reset");
        send(-100, 0, "R9 equal after reset");
        idle(3);
        check(exp_d.size() == 0, "R7 final drain", exp_d.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule